// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block drives the supply selects, enables and reset line of a removable card slot so that the card always goes through a safe power cycle. A power-up request from idle first drops the card enable, then turns both supplies off long enough for the rail to decay and stay off. It then applies 5 V Vcc with Vpp still off and waits for the rail to rise and settle with extra margin. After that it raises the global and card enables, pulses the card reset, and waits a final settling time before it signals completion. A power-down request runs a shorter path: it drops the card enable, turns the supplies off, and waits for the rail to decay.

Every dwell time is a whole number of clock ticks derived from the `CLK_HZ` parameter. A single down-counter times every step and reloads whenever the state machine enters a new state. The outputs are registers that change only on state entry, so between sequences they hold the last applied settings.

States: `ST_IDLE` waits for a request. Power-up runs `ST_UP_CARD_OFF` (20 ms), `ST_UP_PWR_OFF` (420 ms), `ST_UP_VCC_ON` (420 ms), `ST_UP_ENABLE` (200 ms), `ST_UP_RESET` (reset width) and `ST_UP_SETTLE` (20 ms). Power-down runs `ST_DN_CARD_OFF` (20 ms) and `ST_DN_PWR_OFF` (320 ms). Both paths finish in `ST_DONE`, which lasts one cycle. The transitions are as follows. `ST_IDLE` goes to `ST_UP_CARD_OFF` on `req_up`, or to `ST_DN_CARD_OFF` on `req_dn` alone. Each timed state advances to the next in its path when its dwell expires. `ST_UP_SETTLE` and `ST_DN_PWR_OFF` both advance to `ST_DONE`. `ST_DONE` returns to `ST_IDLE`.

Top module: `sock_pwr_seq`

## Requirements
- R1: After reset, `vcc_sel` and `vpp_sel` are 2'b00 (0 V), and `card_en`, `glob_en`, `card_rst`, `busy`, `ready` and `powered` are all low.
- R2: A `req_up` sampled high in idle clears `card_en` and raises `busy` at that same clock edge, and `card_en` stays low for 20 ms of ticks.
- R3: On the power-up path, both supply selects then read 2'b00 for 420 ms of ticks (20 ms + 300 ms decay + 100 ms off time).
- R4: `vcc_sel` then reads 2'b01 (5 V) with `vpp_sel` at 2'b00 for 420 ms of ticks before any enable rises.
- R5: `glob_en` and `card_en` then both rise at the same edge and hold for 200 ms of ticks before the card reset begins.
- R6: `card_rst` is then high for the reset width, which is 10 µs rounded up to whole ticks and never less than one tick. After it falls, the completion pulse follows 20 ms of ticks later.
- R7: A `req_dn` sampled high in idle clears `card_en` for 20 ms of ticks, then sets both selects to 2'b00 for 320 ms of ticks, then completes. `glob_en` is left unchanged on this path.
- R8: `busy` is high from the edge that starts a sequence through the cycle of its completion pulse. Requests sampled at any other time than idle have no effect, including a request sampled in the completion cycle.
- R9: `ready` is high for exactly one cycle at the end of each sequence.
- R10: `powered` rises together with the completion pulse of power-up and falls at the edge that starts any new sequence.
- R11: When `req_up` and `req_dn` are both high in idle, the power-up path runs.
- R12: One millisecond of dwell equals `CLK_HZ/1000` ticks, with a minimum of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_up | input | 1 | Power-up request, sampled in idle |
| req_dn | input | 1 | Power-down request, sampled in idle |
| vcc_sel | output | 2 | Vcc select: 2'b00 = 0 V, 2'b01 = 5 V |
| vpp_sel | output | 2 | Vpp select: 2'b00 = 0 V |
| card_en | output | 1 | Card interface enable |
| glob_en | output | 1 | Global interrupt-drive enable |
| card_rst | output | 1 | Card reset, active high |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | One-cycle completion pulse |
| powered | output | 1 | Power-up has completed and no sequence has started since |

## Verification
The assertions check, on every cycle, the safety relations between the outputs. The card enable never stands without 5 V Vcc. Reset only occurs while the card is powered and enabled. The `powered` flag implies a live, enabled card out of reset. `ready` lasts a single cycle inside `busy`. The supply and global-enable outputs do not move while idle. None of these checks can see the dwell lengths. The exact tick at which each step begins, the ignored mid-sequence and completion-cycle requests, and the up-over-down priority are shown only by the bench. The bench compares every output on every cycle of each sequence against a schedule that it computes from `CLK_HZ`.

// File: rtl/sock_pwr_pkg.sv
package sock_pwr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UP_CARD_OFF,
        ST_UP_PWR_OFF,
        ST_UP_VCC_ON,
        ST_UP_ENABLE,
        ST_UP_RESET,
        ST_UP_SETTLE,
        ST_DN_CARD_OFF,
        ST_DN_PWR_OFF,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] VCC_OFF = 2'b00;
    localparam logic [1:0] VCC_5V  = 2'b01;
    localparam logic [1:0] VPP_OFF = 2'b00;

    typedef struct packed {
        logic [1:0] vcc;
        logic [1:0] vpp;
        logic       card_en;
        logic       glob_en;
        logic       card_rst;
        logic       powered;
        logic       busy;
        logic       ready;
    } sock_drive_t;

endpackage

// File: rtl/sock_dwell_timer.sv
module sock_dwell_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sock_seq_fsm.sv
module sock_seq_fsm
    import sock_pwr_pkg::*;
#(
    parameter int unsigned TICKS_MS  = 5,
    parameter int unsigned RST_TICKS = 1,
    parameter int unsigned CW        = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_up,
    input  logic          req_dn,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output sock_drive_t   drv
);

    localparam int unsigned D_CARD_OFF   = 20 * TICKS_MS;
    localparam int unsigned D_UP_PWR_OFF = (20 + 300 + 100) * TICKS_MS;
    localparam int unsigned D_VCC_ON     = (100 + 20 + 300) * TICKS_MS;
    localparam int unsigned D_ENABLE     = 200 * TICKS_MS;
    localparam int unsigned D_SETTLE     = 20 * TICKS_MS;
    localparam int unsigned D_DN_PWR_OFF = (20 + 300) * TICKS_MS;

    seq_state_e state, state_nx;

    function automatic logic [CW-1:0] dwell_of(seq_state_e s);
        logic [CW-1:0] d;
        unique case (s)
            ST_UP_CARD_OFF,
            ST_DN_CARD_OFF: d = CW'(D_CARD_OFF);
            ST_UP_PWR_OFF:  d = CW'(D_UP_PWR_OFF);
            ST_UP_VCC_ON:   d = CW'(D_VCC_ON);
            ST_UP_ENABLE:   d = CW'(D_ENABLE);
            ST_UP_RESET:    d = CW'(RST_TICKS);
            ST_UP_SETTLE:   d = CW'(D_SETTLE);
            ST_DN_PWR_OFF:  d = CW'(D_DN_PWR_OFF);
            default:        d = CW'(1);
        endcase
        return d;
    endfunction

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_up)      state_nx = ST_UP_CARD_OFF;
                else if (req_dn) state_nx = ST_DN_CARD_OFF;
            end
            ST_UP_CARD_OFF: if (expired) state_nx = ST_UP_PWR_OFF;
            ST_UP_PWR_OFF:  if (expired) state_nx = ST_UP_VCC_ON;
            ST_UP_VCC_ON:   if (expired) state_nx = ST_UP_ENABLE;
            ST_UP_ENABLE:   if (expired) state_nx = ST_UP_RESET;
            ST_UP_RESET:    if (expired) state_nx = ST_UP_SETTLE;
            ST_UP_SETTLE:   if (expired) state_nx = ST_DONE;
            ST_DN_CARD_OFF: if (expired) state_nx = ST_DN_PWR_OFF;
            ST_DN_PWR_OFF:  if (expired) state_nx = ST_DONE;
            ST_DONE:        if (expired) state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    assign load     = (state_nx != state);
    assign load_val = dwell_of(state_nx);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs: applied on entry to each state, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv <= '{vcc: VCC_OFF, vpp: VPP_OFF, default: 1'b0};
        end else begin
            drv.busy  <= (state_nx != ST_IDLE);
            drv.ready <= (state_nx == ST_DONE);
            if (state_nx != state) begin
                unique case (state_nx)
                    ST_UP_CARD_OFF,
                    ST_DN_CARD_OFF: begin
                        drv.card_en <= 1'b0;
                        drv.powered <= 1'b0;
                    end
                    ST_UP_PWR_OFF,
                    ST_DN_PWR_OFF: begin
                        drv.vcc <= VCC_OFF;
                        drv.vpp <= VPP_OFF;
                    end
                    ST_UP_VCC_ON: begin
                        drv.vcc <= VCC_5V;
                        drv.vpp <= VPP_OFF;
                    end
                    ST_UP_ENABLE: begin
                        drv.glob_en <= 1'b1;
                        drv.card_en <= 1'b1;
                    end
                    ST_UP_RESET:  drv.card_rst <= 1'b1;
                    ST_UP_SETTLE: drv.card_rst <= 1'b0;
                    ST_DONE: begin
                        if (state == ST_UP_SETTLE) drv.powered <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sock_pwr_seq.sv
module sock_pwr_seq
    import sock_pwr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_up,
    input  logic       req_dn,
    output logic [1:0] vcc_sel,
    output logic [1:0] vpp_sel,
    output logic       card_en,
    output logic       glob_en,
    output logic       card_rst,
    output logic       busy,
    output logic       ready,
    output logic       powered
);

    localparam int unsigned MS_RAW    = CLK_HZ / 1000;
    localparam int unsigned TICKS_MS  = (MS_RAW < 1) ? 1 : MS_RAW;
    localparam int unsigned RST_RAW   = (10 * CLK_HZ + 999_999) / 1_000_000;
    localparam int unsigned RST_TICKS = (RST_RAW < 1) ? 1 : RST_RAW;
    localparam int unsigned MAX_DWELL = (420 * TICKS_MS > RST_TICKS) ? 420 * TICKS_MS : RST_TICKS;
    localparam int unsigned CW        = $clog2(MAX_DWELL + 1);

    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;
    sock_drive_t   drv;

    sock_dwell_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sock_seq_fsm #(
        .TICKS_MS  (TICKS_MS),
        .RST_TICKS (RST_TICKS),
        .CW        (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_up   (req_up),
        .req_dn   (req_dn),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .drv      (drv)
    );

    assign vcc_sel  = drv.vcc;
    assign vpp_sel  = drv.vpp;
    assign card_en  = drv.card_en;
    assign glob_en  = drv.glob_en;
    assign card_rst = drv.card_rst;
    assign busy     = drv.busy;
    assign ready    = drv.ready;
    assign powered  = drv.powered;

endmodule

// File: rtl/sock_pwr_seq_chk.sv
module sock_pwr_seq_chk
    import sock_pwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_up,
    input logic       req_dn,
    input logic [1:0] vcc_sel,
    input logic [1:0] vpp_sel,
    input logic       card_en,
    input logic       glob_en,
    input logic       card_rst,
    input logic       busy,
    input logic       ready,
    input logic       powered
);

    // R9: completion pulse lasts one cycle
    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R8: completion pulse lies inside busy
    a_r8_ready_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> busy);

    // R8: idle with no request stays idle
    a_r8_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_up && !req_dn) |=> !busy);

    // R8: supplies and global enable frozen while idle
    a_r8_idle_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(vcc_sel) && $stable(vpp_sel) && $stable(glob_en)));

    // R4: card enable only with 5 V applied
    a_r4_enable_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        card_en |-> (vcc_sel == VCC_5V));

    // R6: reset only while powered and enabled
    a_r6_reset_when_live: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (vcc_sel == VCC_5V && card_en && glob_en));

    // R10: powered implies a live card out of reset
    a_r10_powered_live: assert property (@(posedge clk) disable iff (!rst_n)
        powered |-> (vcc_sel == VCC_5V && card_en && !card_rst));

    // R10: powered rises only with the completion pulse
    a_r10_powered_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |-> ready);

endmodule

bind sock_pwr_seq sock_pwr_seq_chk u_chk (.*);

// File: tb/sock_pwr_seq_test.sv
module sock_pwr_seq_test;

    localparam int unsigned HZ = 5000;
    localparam int unsigned T  = HZ / 1000;
    localparam int unsigned R  = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_up = 1'b0;
    logic       req_dn = 1'b0;
    logic [1:0] vcc_sel, vpp_sel;
    logic       card_en, glob_en, card_rst, busy, ready, powered;

    int n_chk = 0;
    int n_err = 0;

    logic [1:0] m_vcc = 2'b00;
    logic [1:0] m_vpp = 2'b00;
    logic       m_card = 1'b0, m_glob = 1'b0, m_rst = 1'b0, m_pow = 1'b0;

    sock_pwr_seq #(.CLK_HZ(HZ)) uut (
        .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_dn(req_dn),
        .vcc_sel(vcc_sel), .vpp_sel(vpp_sel), .card_en(card_en),
        .glob_en(glob_en), .card_rst(card_rst), .busy(busy),
        .ready(ready), .powered(powered)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp, input int k);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s at step %0d: actual %0d expected %0d", tag, what, k, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag, input bit e_busy, input bit e_ready, input int k);
        chk(tag, "vcc_sel",  int'(vcc_sel),  int'(m_vcc),  k);
        chk(tag, "vpp_sel",  int'(vpp_sel),  int'(m_vpp),  k);
        chk(tag, "card_en",  int'(card_en),  int'(m_card), k);
        chk(tag, "glob_en",  int'(glob_en),  int'(m_glob), k);
        chk(tag, "card_rst", int'(card_rst), int'(m_rst),  k);
        chk(tag, "powered",  int'(powered),  int'(m_pow),  k);
        chk(tag, "busy",     int'(busy),     int'(e_busy), k);
        chk(tag, "ready",    int'(ready),    int'(e_ready), k);
    endtask

    // power-up run; both_req starts it with both requests (R11); poke injects ignored requests
    task automatic run_up(input bit both_req, input bit poke);
        int total;
        string tag;
        total = 1080 * T + R;
        @(negedge clk);
        req_up = 1'b1;
        req_dn = both_req;
        for (int k = 0; k <= total + 2; k++) begin
            @(negedge clk);
            if (k == 0)            begin m_card = 1'b0; m_pow = 1'b0; end
            if (k == 20 * T)       begin m_vcc = 2'b00; m_vpp = 2'b00; end
            if (k == 440 * T)      begin m_vcc = 2'b01; m_vpp = 2'b00; end
            if (k == 860 * T)      begin m_glob = 1'b1; m_card = 1'b1; end
            if (k == 1060 * T)     m_rst = 1'b1;
            if (k == 1060 * T + R) m_rst = 1'b0;
            if (k == total)        m_pow = 1'b1;
            if (k == 0)                     tag = both_req ? "R11" : "R2";
            else if (k == 20 * T)           tag = "R12";
            else if (k < 20 * T)            tag = "R2";
            else if (k < 440 * T)           tag = "R3";
            else if (k < 860 * T)           tag = "R4";
            else if (k < 1060 * T)          tag = "R5";
            else if (k < total)             tag = "R6";
            else if (k == total)            tag = "R9";
            else                            tag = "R8";
            cmp_all(tag, k <= total, k == total, k);
            req_up = 1'b0;
            req_dn = 1'b0;
            if (poke) begin
                if (k == 7)          req_dn = 1'b1;
                if (k == 500 * T)    req_up = 1'b1;
                if (k == total - 1)  req_dn = 1'b1;
                if (k == total)      req_up = 1'b1;
            end
        end
    endtask

    task automatic run_dn(input bit poke);
        int total;
        string tag;
        total = 340 * T;
        @(negedge clk);
        req_dn = 1'b1;
        for (int k = 0; k <= total + 2; k++) begin
            @(negedge clk);
            if (k == 0)      begin m_card = 1'b0; m_pow = 1'b0; end
            if (k == 20 * T) begin m_vcc = 2'b00; m_vpp = 2'b00; end
            if (k < total)        tag = "R7";
            else if (k == total)  tag = "R9";
            else                  tag = "R8";
            cmp_all(tag, k <= total, k == total, k);
            req_up = 1'b0;
            req_dn = 1'b0;
            if (poke) begin
                if (k == 3)     req_up = 1'b1;
                if (k == total) req_up = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R1", 1'b0, 1'b0, 0);
        // idle without requests: nothing moves (R8)
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cmp_all("R8", 1'b0, 1'b0, i);
        end
        run_dn(1'b0);        // R7 from an unpowered socket
        run_up(1'b1, 1'b1);  // R11 priority, ignored requests
        run_dn(1'b1);        // R7 with glob_en left high, ignored requests
        run_up(1'b0, 1'b0);  // R2..R6 plain
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule